// File: doc/BRIEF.md
# Serial Transceiver with Packed-Command Host Port

This block is an 8-bit asynchronous serial transceiver. Frames carry one low start bit, eight data bits sent and received least significant bit first, and one high stop bit; the line rests high. A programmable divider produces a tick enable at sixteen times the bit rate. The transmitter and the receiver both run from that tick. The receiver takes its samples at the middle of each bit.

The host side is a single byte-wide port. In each access the host presents one command byte and, for writes, one data byte. The command byte says whether the access is a read or a write, and whether it targets the queue or the small register file. For a register access it also names one of eight addresses. One physical data register holds outgoing and incoming data alike. A queue write loads it and schedules a transmission, and every completed reception overwrites it. Received bytes are also kept in a three-entry receive queue that the host drains with queue reads. A status register reports the following:
- the transmitter is busy;
- receive data is waiting;
- a receive overrun occurred;
- a framing error occurred;
- a malformed command arrived.

The divisor is 16 bits wide, split over two byte registers. With divisor D, one tick occurs every D+1 clocks and one bit lasts 16·(D+1) clocks.

Top module: `uart_cmd_host`

## Requirements
- R1: After reset the status register (address 1) reads 0, txd is high, and the divisor reads 26 (address 2 = 0x1A, address 3 = 0x00).
- R2: A command byte with bits 7..5 zero is decoded as follows: bit 4 = 1 means a register access and bit 4 = 0 means a queue access; bit 3 = 1 means a write and bit 3 = 0 means a read; bits 2..0 give the register address. A read returns its byte on host_rdata with host_rvalid high exactly one cycle after the command cycle. Writes never raise host_rvalid.
- R3: A command byte with any of bits 7..5 set changes nothing and raises no host_rvalid. It sets the sticky command-error flag, status bit 4.
- R4: A queue write (command 0x08) loads the shared data register and transmits it. The transmitted frame is a low start bit, then data LSB first, then a high stop bit, each bit lasting 16·(D+1) clocks.
- R5: Status bit 0 is high from the cycle after a queue write until the stop bit has ended, and low otherwise.
- R6: The receiver samples rxd at mid-bit, 16 ticks per bit, LSB first. Each completed byte is pushed into the receive queue and overwrites the shared data register (register address 0).
- R7: The receive queue holds 3 bytes. A queue read (command 0x00) returns the oldest byte and removes it; a queue read on an empty queue returns 0. Status bit 1 is set while the queue is non-empty, and register address 4 reads the fill count.
- R8: A byte completed while the queue is full is dropped from the queue, which keeps its contents, and sets the sticky overrun flag, status bit 2.
- R9: A byte whose stop bit samples low is still stored and sets the sticky framing-error flag, status bit 3.
- R10: Writing register address 1 clears each of status bits 2..4 whose written data bit is 1.
- R11: Register address 2 holds divisor bits 7..0 and address 3 holds bits 15..8, both readable and writable.
- R12: A register write to address 0 loads the shared data register without starting a transmission: txd stays high and status bit 0 stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Command cycle strobe |
| host_cmd | input | 8 | Packed command byte |
| host_wdata | input | 8 | Write data for write commands |
| host_rdata | output | 8 | Read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after a read command |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |

## Verification
Every host read result appears on the clock edge after the command cycle. The bench therefore drives each command on a falling edge and samples host_rdata at the next falling edge. Status and count checks are timed the same way.

Serial timing is measured in bit periods of 64 clocks, with the divisor programmed to 3. Transmit bits are sampled near their middles, counted from the observed falling edge of the start bit. Receive frames are driven with the same period, and their results are read only after the full frame plus an idle bit. The roughly 2-clock synchronizer delay and the up-to-4-clock tick alignment therefore never decide a check.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_DIVL = 3'd2;
  localparam logic [2:0] A_DIVH = 3'd3;
  localparam logic [2:0] A_CNT  = 3'd4;

  typedef struct packed {
    logic       bad;
    logic       is_reg;
    logic       is_wr;
    logic [2:0] addr;
  } cmd_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  function automatic cmd_t decode_cmd(input logic [7:0] c);
    cmd_t d;
    d.bad    = |c[7:5];
    d.is_reg = c[4];
    d.is_wr  = c[3];
    d.addr   = c[2:0];
    return d;
  endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= div;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int OVS = 16,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         txd,
  output logic         busy
);
  localparam int OW = $clog2(OVS);
  localparam int FW = W + 2;
  localparam int BW = $clog2(FW);

  logic [FW-1:0] frame;
  logic [OW-1:0] ocnt;
  logic [BW-1:0] bitn;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame <= '1;
      ocnt  <= '0;
      bitn  <= '0;
      txd   <= 1'b1;
      busy  <= 1'b0;
    end else if (!busy) begin
      if (load) begin
        frame <= {1'b1, din, 1'b0};
        txd   <= 1'b0;
        busy  <= 1'b1;
        ocnt  <= '0;
        bitn  <= '0;
      end
    end else if (tick) begin
      if (ocnt == OW'(OVS - 1)) begin
        ocnt <= '0;
        if (bitn == BW'(FW - 1)) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          bitn  <= bitn + 1'b1;
          frame <= {1'b1, frame[FW-1:1]};
          txd   <= frame[1];
        end
      end else begin
        ocnt <= ocnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_cmd_pkg::*;
#(
  parameter int OVS = 16,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         rxd,
  output logic         done,
  output logic [W-1:0] data,
  output logic         ferr
);
  localparam int OW = $clog2(OVS);
  localparam int BW = $clog2(W);

  logic          s1, s2;
  rx_state_t     st;
  logic [OW-1:0] ocnt;
  logic [BW-1:0] bitn;
  logic [W-1:0]  sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_IDLE;
      ocnt <= '0;
      bitn <= '0;
      sh   <= '0;
      done <= 1'b0;
      data <= '0;
      ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (!s2) begin
            st   <= RX_START;
            ocnt <= '0;
          end
          RX_START: if (ocnt == OW'(OVS / 2 - 1)) begin
            ocnt <= '0;
            bitn <= '0;
            st   <= s2 ? RX_IDLE : RX_DATA;
          end else ocnt <= ocnt + 1'b1;
          RX_DATA: if (ocnt == OW'(OVS - 1)) begin
            ocnt <= '0;
            sh   <= {s2, sh[W-1:1]};
            if (bitn == BW'(W - 1)) st <= RX_STOP;
            else bitn <= bitn + 1'b1;
          end else ocnt <= ocnt + 1'b1;
          default: if (ocnt == OW'(OVS - 1)) begin
            ocnt <= '0;
            done <= 1'b1;
            data <= sh;
            ferr <= !s2;
            st   <= RX_IDLE;
          end else ocnt <= ocnt + 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_cmd_host.sv
module uart_cmd_host
  import uart_cmd_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 26,
  parameter int OVS       = 16,
  parameter int RX_DEPTH  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_valid,
  input  logic [7:0] host_cmd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_rvalid,
  output logic       txd,
  input  logic       rxd
);
  localparam int CW = $clog2(RX_DEPTH + 1);

  cmd_t             cmd;
  logic             cmd_ok, q_wr, q_rd, r_wr;
  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic [7:0]       shared_q;
  logic             tx_pend, tx_busy, tx_load;
  logic             rx_done, rx_ferr;
  logic [7:0]       rx_data;
  logic [7:0]       fifo_dout;
  logic [CW-1:0]    fifo_cnt;
  logic             fifo_full, fifo_empty, fifo_pop;
  logic             ovr_q, ferr_q, cerr_q;
  logic [7:0]       status;

  assign cmd      = decode_cmd(host_cmd);
  assign cmd_ok   = host_valid && !cmd.bad;
  assign q_wr     = cmd_ok && !cmd.is_reg && cmd.is_wr;
  assign q_rd     = cmd_ok && !cmd.is_reg && !cmd.is_wr;
  assign r_wr     = cmd_ok && cmd.is_reg && cmd.is_wr;
  assign fifo_pop = q_rd && !fifo_empty;
  assign tx_load  = tx_pend && !tx_busy;
  assign status   = {3'b000, cerr_q, ferr_q, ovr_q, !fifo_empty, tx_pend | tx_busy};

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .div(div_q), .tick(tick)
  );

  uart_tx #(.OVS(OVS), .W(8)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .load(tx_load), .din(shared_q),
    .txd(txd), .busy(tx_busy)
  );

  uart_rx #(.OVS(OVS), .W(8)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
    .done(rx_done), .data(rx_data), .ferr(rx_ferr)
  );

  uart_rx_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(rx_done), .din(rx_data), .pop(fifo_pop),
    .dout(fifo_dout), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  // shared data register: host write wins over a same-cycle reception
  always_ff @(posedge clk) begin
    if (rst) shared_q <= '0;
    else if (q_wr || (r_wr && cmd.addr == A_DATA)) shared_q <= host_wdata;
    else if (rx_done) shared_q <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) tx_pend <= 1'b0;
    else if (q_wr) tx_pend <= 1'b1;
    else if (tx_load) tx_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) div_q <= DIV_W'(DIV_RESET);
    else if (r_wr && cmd.addr == A_DIVL) div_q[7:0] <= host_wdata;
    else if (r_wr && cmd.addr == A_DIVH) div_q[DIV_W-1:8] <= host_wdata[DIV_W-9:0];
  end

  // sticky flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
      cerr_q <= 1'b0;
    end else begin
      if (rx_done && fifo_full) ovr_q <= 1'b1;
      else if (r_wr && cmd.addr == A_STAT && host_wdata[2]) ovr_q <= 1'b0;
      if (rx_done && rx_ferr) ferr_q <= 1'b1;
      else if (r_wr && cmd.addr == A_STAT && host_wdata[3]) ferr_q <= 1'b0;
      if (host_valid && cmd.bad) cerr_q <= 1'b1;
      else if (r_wr && cmd.addr == A_STAT && host_wdata[4]) cerr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= cmd_ok && !cmd.is_wr;
      if (q_rd) host_rdata <= fifo_empty ? 8'h00 : fifo_dout;
      else if (cmd_ok && cmd.is_reg && !cmd.is_wr) begin
        case (cmd.addr)
          A_DATA:  host_rdata <= shared_q;
          A_STAT:  host_rdata <= status;
          A_DIVL:  host_rdata <= div_q[7:0];
          A_DIVH:  host_rdata <= 8'(div_q[DIV_W-1:8]);
          A_CNT:   host_rdata <= 8'(fifo_cnt);
          default: host_rdata <= 8'h00;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_cmd_host_chk.sv
module uart_cmd_host_chk #(
  parameter int DEPTH = 3,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          host_valid,
  input logic [7:0]    host_cmd,
  input logic          host_rvalid,
  input logic          txd,
  input logic          tx_busy,
  input logic          rx_done,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_cnt,
  input logic          ovr_q
);
  p_read_answers_r2: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_cmd[7:5] == 3'b000 && !host_cmd[3]) |=> host_rvalid);

  p_write_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_cmd[3]) |=> !host_rvalid);

  p_bad_cmd_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_cmd[7:5] != 3'b000) |=> !host_rvalid);

  p_idle_line_high_r4: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  p_start_bit_low_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> !txd);

  p_fifo_bound_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));

  p_overrun_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_done && fifo_full) |=> ovr_q);

  p_full_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !host_valid) |=> fifo_full);
endmodule

bind uart_cmd_host uart_cmd_host_chk #(.DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .host_valid(host_valid), .host_cmd(host_cmd),
  .host_rvalid(host_rvalid), .txd(txd), .tx_busy(tx_busy),
  .rx_done(rx_done), .fifo_full(fifo_full), .fifo_cnt(fifo_cnt), .ovr_q(ovr_q)
);

// File: tb/tb_uart_cmd_host.sv
`timescale 1ns/1ps
module tb_uart_cmd_host;
  localparam int BIT = 64; // divisor 3 -> 4 clocks per tick, 16 ticks per bit

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_valid = 1'b0;
  logic [7:0] host_cmd = 8'h00;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       host_rvalid;
  logic       txd;
  logic       rxd = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  uart_cmd_host dut (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_cmd(host_cmd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .txd(txd), .rxd(rxd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] c, input logic [7:0] wd,
                    output logic [7:0] rd, output logic rv);
    @(negedge clk);
    host_valid = 1'b1; host_cmd = c; host_wdata = wd;
    @(negedge clk);
    host_valid = 1'b0;
    rd = host_rdata; rv = host_rvalid;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] rd);
    logic rv;
    op(8'h10 | 8'(a), 8'h00, rd, rv);
    chk("R2 rvalid on register read", int'(rv), 1);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] rd; logic rv;
    op(8'h18 | 8'(a), d, rd, rv);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    @(negedge clk);
    rxd = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i]; repeat (BIT) @(negedge clk);
    end
    rxd = stop; repeat (BIT) @(negedge clk);
    rxd = 1'b1; repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] r;
    chk("R1 txd idle", int'(txd), 1);
    rd_reg(3'd1, r); chk("R1 status", int'(r), 0);
    rd_reg(3'd2, r); chk("R1 divisor low", int'(r), 8'h1A);
    rd_reg(3'd3, r); chk("R1 divisor high", int'(r), 0);
  endtask

  task automatic t_divisor;
    logic [7:0] r;
    wr_reg(3'd3, 8'h5C); rd_reg(3'd3, r); chk("R11 divisor high", int'(r), 8'h5C);
    wr_reg(3'd3, 8'h00); wr_reg(3'd2, 8'h03);
    rd_reg(3'd2, r); chk("R11 divisor low", int'(r), 8'h03);
    repeat (100) @(negedge clk);
  endtask

  task automatic t_bad_cmd;
    logic [7:0] r; logic rv;
    wr_reg(3'd0, 8'h11);
    op(8'h38, 8'h55, r, rv); chk("R3 no rvalid on bad write", int'(rv), 0);
    op(8'h90, 8'h00, r, rv); chk("R3 no rvalid on bad read", int'(rv), 0);
    rd_reg(3'd0, r); chk("R3 data reg untouched", int'(r), 8'h11);
    rd_reg(3'd1, r); chk("R3 command error flag", int'(r), 8'h10);
    op(8'h08, 8'h00, r, rv); chk("R2 no rvalid on write", int'(rv), 0);
    wait (txd == 1'b0);
    repeat (12 * BIT) @(negedge clk);
    wr_reg(3'd1, 8'h10); rd_reg(3'd1, r); chk("R10 clear command error", int'(r), 0);
  endtask

  task automatic t_reg0_no_tx;
    logic [7:0] r;
    bit low = 1'b0;
    wr_reg(3'd0, 8'hA5);
    rd_reg(3'd0, r); chk("R12 data reg loaded", int'(r), 8'hA5);
    for (int i = 0; i < 3 * BIT; i++) begin
      @(negedge clk); if (!txd) low = 1'b1;
    end
    chk("R12 txd stays high", int'(low), 0);
    rd_reg(3'd1, r); chk("R12 busy stays low", int'(r[0]), 0);
  endtask

  task automatic t_tx(input logic [7:0] b);
    logic [7:0] r, got; logic rv;
    @(negedge clk);
    host_valid = 1'b1; host_cmd = 8'h08; host_wdata = b;
    @(negedge clk);
    host_valid = 1'b0;
    @(negedge txd);
    rd_reg(3'd1, r); chk("R5 busy during frame", int'(r[0]), 1);
    repeat (BIT / 2 - 3) @(negedge clk);
    chk("R4 start bit low", int'(txd), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk); got[i] = txd;
    end
    chk("R4 data LSB first", int'(got), int'(b));
    repeat (BIT) @(negedge clk);
    chk("R4 stop bit high", int'(txd), 1);
    repeat (BIT) @(negedge clk);
    rd_reg(3'd1, r); chk("R5 busy clear after frame", int'(r[0]), 0);
    op(8'h00, 8'h00, r, rv); chk("R7 empty queue read", int'(r), 0);
  endtask

  task automatic t_rx;
    logic [7:0] r; logic rv;
    send_rx(8'h5A, 1'b1);
    rd_reg(3'd0, r); chk("R6 shared reg holds received", int'(r), 8'h5A);
    rd_reg(3'd1, r); chk("R7 data available", int'(r), 8'h02);
    rd_reg(3'd4, r); chk("R7 count one", int'(r), 1);
    op(8'h00, 8'h00, r, rv);
    chk("R7 queue read valid", int'(rv), 1);
    chk("R6 received LSB first", int'(r), 8'h5A);
    rd_reg(3'd4, r); chk("R7 count zero", int'(r), 0);
  endtask

  task automatic t_overrun;
    logic [7:0] r; logic rv;
    send_rx(8'h11, 1'b1); send_rx(8'h22, 1'b1); send_rx(8'h33, 1'b1);
    rd_reg(3'd1, r); chk("R8 no overrun at three", int'(r), 8'h02);
    send_rx(8'h44, 1'b1);
    rd_reg(3'd4, r); chk("R7 count three", int'(r), 3);
    rd_reg(3'd1, r); chk("R8 overrun flag", int'(r), 8'h06);
    rd_reg(3'd0, r); chk("R6 shared reg overwritten", int'(r), 8'h44);
    op(8'h00, 8'h00, r, rv); chk("R8 oldest kept 1", int'(r), 8'h11);
    op(8'h07, 8'h00, r, rv); chk("R8 oldest kept 2", int'(r), 8'h22);
    op(8'h00, 8'h00, r, rv); chk("R8 oldest kept 3", int'(r), 8'h33);
    op(8'h00, 8'h00, r, rv); chk("R7 empty after drain", int'(r), 0);
    wr_reg(3'd1, 8'h04); rd_reg(3'd1, r); chk("R10 clear overrun", int'(r), 0);
  endtask

  task automatic t_ferr;
    logic [7:0] r; logic rv;
    send_rx(8'h81, 1'b0);
    rd_reg(3'd1, r); chk("R9 framing error flag", int'(r), 8'h0A);
    op(8'h00, 8'h00, r, rv); chk("R9 byte still stored", int'(r), 8'h81);
    wr_reg(3'd1, 8'h08); rd_reg(3'd1, r); chk("R10 clear framing error", int'(r), 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_divisor();
    t_bad_cmd();
    t_reg0_no_tx();
    t_tx(8'h3C);
    t_tx(8'hC5);
    t_rx();
    t_overrun();
    t_ferr();
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end
endmodule